// File: doc/BRIEF.md
# Timebase Tick and Input Pulse Capture Unit

This unit gives a nibble-wide controller two small real-time services. The first is a free-running timebase. A counter advances once per instruction cycle, and each time it wraps it sets a sticky tick-pending flag. A timer-test strobe from the instruction decoder reads this flag. If the flag is set, the unit requests a skip of the next instruction and clears the flag. If the flag is clear, no skip is requested.

The second service is a pair of event catchers, one per pulse input. Each catcher samples its input once per instruction cycle. Its latch is set only by a falling edge after which the input stays low for at least two consecutive samples. A read-latches strobe returns a 4-bit word to the accumulator path and clears both latches, so that later pulses can be caught. Reset does not clear the latches. Any pulse caught before a reset can therefore still be read after it.

The timebase is a two-state machine. In TICK_IDLE, a counter wrap takes the WRAP transition to TICK_PENDING. In TICK_PENDING, a test strobe takes the CONSUME transition back to TICK_IDLE, unless the counter wraps in that same cycle. In that case the machine stays in TICK_PENDING.

Each event catcher is a three-state machine, and it moves only in enabled cycles:
- CAP_WAIT_HIGH goes to CAP_ARMED on a high sample (ARM).
- CAP_ARMED goes to CAP_LOW_RUN on a low sample (FALL).
- CAP_LOW_RUN goes back to CAP_ARMED on a high sample (GLITCH), because the low did not last long enough.
- When the required number of low samples is reached, the catcher takes the QUALIFY transition back to CAP_WAIT_HIGH and sets its latch.

Top module: `tick_event_unit`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears the timebase counter and the tick-pending flag, and puts both catchers in CAP_WAIT_HIGH. After reset, a timer test requests no skip.
- R2: The tick-pending flag becomes set at the enabled clock edge on which the counter wraps. With the default TB_W=10, this is the 1024th enabled cycle after reset, and a test in the 1025th enabled cycle requests a skip.
- R3: skip_req is high only in an enabled cycle in which tmr_test is high and the flag is set. That cycle's edge clears the flag, so a test in the following enabled cycle requests no skip. A test that finds the flag clear requests no skip.
- R4: If a consuming test and a counter wrap fall on the same enabled edge, the flag stays set, and the next test also requests a skip.
- R5: In cycles with cyc_en low, the counter does not advance, tmr_test and rd_lat have no effect, and the pulse inputs are not sampled.
- R6: A catcher's latch sets after a high sample followed by QUAL_LEN consecutive low samples (default 2). A single low sample between high samples does not set it.
- R7: An input that stays low after qualifying does not set the latch again until the input has been sampled high and then falls again.
- R8: rd_word bit 3 is the ev_hi latch, bit 2 is clk_stat, bit 1 is always 0 and bit 0 is the ev_lo latch.
- R9: An enabled cycle with rd_lat high clears both latches at its edge.
- R10: If a pulse qualifies in the same enabled cycle as a read, that latch stays set for the next read.
- R11: Reset leaves the event latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-clock pulse marking an instruction cycle |
| ev_hi | input | 1 | Pulse input whose latch drives word bit 3 |
| ev_lo | input | 1 | Pulse input whose latch drives word bit 0 |
| clk_stat | input | 1 | Clock-generator status, passed to word bit 2 |
| tmr_test | input | 1 | Timer-test strobe, qualified by cyc_en |
| rd_lat | input | 1 | Read-latches strobe, qualified by cyc_en |
| skip_req | output | 1 | Skip request for the next instruction |
| rd_word | output | 4 | Read word for the accumulator |

## Verification
A table of per-cycle input vectors drives the two pulse inputs with several patterns:
- lows lasting one sample, which tell a glitch apart from a qualifying pulse;
- lows lasting two samples, on each input separately and on both together;
- an input held low across a read, which shows that a level is not re-detected;
- a qualification landing on a read cycle, which checks the set-over-clear priority.

The timebase is tested with dense and with gapped cycle enables. The test strobe is placed just before, at and just after the wrap cycle, which distinguishes an off-by-one wrap, a flag that fails to clear, and a wrap lost to a simultaneous test. Strobes and low inputs are also held during disabled cycles, and the latches are read across a reset.

// File: rtl/tick_event_pkg.sv
package tick_event_pkg;

    typedef enum logic [1:0] {
        CAP_WAIT_HIGH = 2'd0,
        CAP_ARMED     = 2'd1,
        CAP_LOW_RUN   = 2'd2
    } cap_state_e;

    typedef enum logic {
        TICK_IDLE    = 1'b0,
        TICK_PENDING = 1'b1
    } tick_state_e;

    localparam int unsigned WORD_W   = 4;
    localparam int unsigned HI_BIT   = 3;
    localparam int unsigned STAT_BIT = 2;
    localparam int unsigned ZERO_BIT = 1;
    localparam int unsigned LO_BIT   = 0;

endpackage

// File: rtl/tick_divider.sv
module tick_divider
    import tick_event_pkg::*;
#(
    parameter int unsigned TB_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic tmr_test,
    output logic skip_req
);

    localparam logic [TB_W-1:0] CNT_MAX = {TB_W{1'b1}};

    logic [TB_W-1:0] cnt_q;
    logic [TB_W-1:0] cnt_d;
    tick_state_e     tick_q;
    tick_state_e     tick_d;
    logic            wrap;
    logic            test_hit;

    assign wrap     = cyc_en && (cnt_q == CNT_MAX);
    assign test_hit = cyc_en && tmr_test;

    // next-state logic
    always_comb begin
        cnt_d  = cnt_q;
        tick_d = tick_q;
        if (cyc_en) begin
            cnt_d = cnt_q + 1'b1;
        end
        unique case (tick_q)
            TICK_IDLE: begin
                if (wrap) begin
                    tick_d = TICK_PENDING;           // WRAP
                end
            end
            TICK_PENDING: begin
                if (test_hit && !wrap) begin
                    tick_d = TICK_IDLE;              // CONSUME
                end
            end
            default: tick_d = TICK_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= TICK_IDLE;
        end else begin
            cnt_q  <= cnt_d;
            tick_q <= tick_d;
        end
    end

    // outputs
    always_comb begin
        skip_req = test_hit && (tick_q == TICK_PENDING);
    end

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && cnt_q == CNT_MAX) |=> (tick_q == TICK_PENDING));   // R2

    AST_SKIP_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && !(cyc_en && cnt_q == CNT_MAX)) |=> (tick_q == TICK_IDLE));   // R3

    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_q == TICK_PENDING && !(cyc_en && tmr_test)) |=> (tick_q == TICK_PENDING));   // R4

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> ($stable(cnt_q) && $stable(tick_q)));   // R5

endmodule

// File: rtl/pulse_catcher.sv
module pulse_catcher
    import tick_event_pkg::*;
#(
    parameter int unsigned QUAL_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_en,
    input  logic pin,
    input  logic rd_clr,
    output logic caught
);

    localparam int unsigned    LCW      = $clog2(QUAL_LEN + 1);
    localparam logic [LCW-1:0] LAST_RUN = LCW'(QUAL_LEN - 1);

    cap_state_e     state_q;
    cap_state_e     state_d;
    logic [LCW-1:0] run_q;
    logic [LCW-1:0] run_d;
    logic           qualify;
    logic           caught_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        qualify = 1'b0;
        if (cyc_en) begin
            unique case (state_q)
                CAP_WAIT_HIGH: begin
                    if (pin) begin
                        state_d = CAP_ARMED;                 // ARM
                    end
                end
                CAP_ARMED: begin
                    if (!pin) begin
                        if (QUAL_LEN <= 1) begin
                            qualify = 1'b1;                  // QUALIFY
                            state_d = CAP_WAIT_HIGH;
                        end else begin
                            state_d = CAP_LOW_RUN;           // FALL
                            run_d   = LCW'(1);
                        end
                    end
                end
                CAP_LOW_RUN: begin
                    if (pin) begin
                        state_d = CAP_ARMED;                 // GLITCH
                        run_d   = '0;
                    end else if (run_q == LAST_RUN) begin
                        qualify = 1'b1;                      // QUALIFY
                        state_d = CAP_WAIT_HIGH;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + 1'b1;
                    end
                end
                default: state_d = CAP_WAIT_HIGH;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_WAIT_HIGH;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    // event latch: deliberately outside reset, a set beats a clear
    always_ff @(posedge clk) begin
        if (qualify) begin
            caught_q <= 1'b1;
        end else if (cyc_en && rd_clr) begin
            caught_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        caught = caught_q;
    end

    AST_SET_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(caught_q) |-> $past(cyc_en && !pin));   // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && rd_clr && !qualify) |=> !caught_q);   // R9

    AST_SET_BEATS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        qualify |=> caught_q);   // R10

endmodule

// File: rtl/tick_event_unit.sv
module tick_event_unit
    import tick_event_pkg::*;
#(
    parameter int unsigned TB_W     = 10,
    parameter int unsigned QUAL_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              ev_hi,
    input  logic              ev_lo,
    input  logic              clk_stat,
    input  logic              tmr_test,
    input  logic              rd_lat,
    output logic              skip_req,
    output logic [WORD_W-1:0] rd_word
);

    localparam int unsigned NUM_EVT = 2;

    logic [NUM_EVT-1:0] pin_vec;
    logic [NUM_EVT-1:0] caught;

    assign pin_vec = {ev_hi, ev_lo};

    tick_divider #(
        .TB_W (TB_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .tmr_test (tmr_test),
        .skip_req (skip_req)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_cap
        pulse_catcher #(
            .QUAL_LEN (QUAL_LEN)
        ) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .cyc_en (cyc_en),
            .pin    (pin_vec[g]),
            .rd_clr (rd_lat),
            .caught (caught[g])
        );
    end

    // read word assembly
    always_comb begin
        rd_word           = '0;
        rd_word[HI_BIT]   = caught[1];
        rd_word[STAT_BIT] = clk_stat;
        rd_word[ZERO_BIT] = 1'b0;
        rd_word[LO_BIT]   = caught[0];
    end

endmodule

// File: tb/tb_tick_event_unit.sv
module tb_tick_event_unit;

    localparam int CLK_PERIOD = 10;

    // vector fields: {ev_hi, ev_lo, clk_stat, rd_lat, exp_hi_latch, exp_lo_latch}
    localparam logic [5:0] EVT_VEC [0:17] = '{
        6'b110000, 6'b011000, 6'b110000, 6'b001000,
        6'b000000, 6'b001011, 6'b000111, 6'b001000,
        6'b100000, 6'b011000, 6'b000100, 6'b101010,
        6'b110011, 6'b111111, 6'b110000, 6'b011000,
        6'b010000, 6'b111010
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       ev_hi = 1'b1;
    logic       ev_lo = 1'b1;
    logic       clk_stat = 1'b0;
    logic       tmr_test = 1'b0;
    logic       rd_lat = 1'b0;
    logic       skip_req;
    logic [3:0] rd_word;

    int n_checks = 0;
    int n_err = 0;

    tick_event_unit dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .ev_hi    (ev_hi),
        .ev_lo    (ev_lo),
        .clk_stat (clk_stat),
        .tmr_test (tmr_test),
        .rd_lat   (rd_lat),
        .skip_req (skip_req),
        .rd_word  (rd_word)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive one clock's inputs after the falling edge, settle before sampling
    task automatic tick(input logic en, input logic tst, input logic rd,
                        input logic hi, input logic lo, input logic st);
        @(negedge clk);
        cyc_en   = en;
        tmr_test = tst;
        rd_lat   = rd;
        ev_hi    = hi;
        ev_lo    = lo;
        clk_stat = st;
        #2;
    endtask

    function automatic string vec_tag(input int idx);
        case (idx)
            5:       return "R6 vec5";
            7:       return "R7 vec7";
            11:      return "R10 vec11";
            14:      return "R9 vec14";
            default: return "R8 vec";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        // reset, then arm both catchers and clear the latches
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

        // table walk: R6 R7 R8 R9 R10
        for (int i = 0; i < 18; i++) begin
            tick(1'b1, 1'b0, EVT_VEC[i][2], EVT_VEC[i][5], EVT_VEC[i][4], EVT_VEC[i][3]);
            check(vec_tag(i), rd_word,
                  {EVT_VEC[i][1], EVT_VEC[i][3], 1'b0, EVT_VEC[i][0]});
        end

        // R5: read strobe without cycle enable is ignored
        for (int k = 0; k < 4; k++) begin
            tick(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        end
        check("R5 read ignored while disabled", rd_word, 4'b1000);
        // R5: one enabled low sample plus disabled low clocks must not qualify
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        end
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R5 low not sampled while disabled", rd_word, 4'b1000);

        // R11: reset keeps latches
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b0;
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R11 latch survives reset", rd_word, 4'b1000);

        // timebase: enabled cycle 1 after reset
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R1 no skip after reset", {3'b0, skip_req}, 4'h0);
        for (int k = 0; k < 1022; k++) begin
            tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        end
        // enabled cycle 1024: flag still clear, wrap at this edge
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 no skip with flag clear", {3'b0, skip_req}, 4'h0);
        tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R5 test ignored while disabled", {3'b0, skip_req}, 4'h0);
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R2 skip after 1024 enables", {3'b0, skip_req}, 4'h1);
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 flag cleared by test", {3'b0, skip_req}, 4'h0);

        // gapped enables, with tests in the disabled gaps (R5)
        for (int k = 0; k < 1022; k++) begin
            tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
            tick(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        end
        for (int k = 0; k < 1023; k++) begin
            tick(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        end
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R4 skip at wrap cycle", {3'b0, skip_req}, 4'h1);
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R4 wrap kept flag set", {3'b0, skip_req}, 4'h1);
        tick(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R3 cleared after second test", {3'b0, skip_req}, 4'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule